// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Sequencer

This block drives one DRAM bank. It takes a stream of read and write requests, each naming a row and a column. It turns each request into the shortest legal run of bank commands: activate, column read, column write and precharge. Reading a row into the sense amplifiers wipes the cells. An open row therefore has to be precharged, which restores it, before a different row may be activated. The block records which row, if any, sits in the row buffer, and it uses that record to decide how much of the sequence each request needs.

A static select picks the row policy. Under open-page policy a row stays open after an access, so a later access to the same row costs only a column command. Under close-page policy every access is followed at once by a precharge, so each request starts from an idle bank. Four down-counters hold back commands until their minimum spacing has passed: activate to column, precharge to activate, activate to activate, and write to read. Every accepted request is reported as a hit, an empty-bank miss or a conflict.

Top module: `bankctl_top`

## Requirements
- R1: After reset `req_ready` is 1, no command is issued, and the bank holds no open row, so the first request is reported as an empty-bank miss.
- R2: One cycle after a request is accepted (`req_valid` and `req_ready` both 1), `acc_valid` pulses for one cycle and `acc_kind` reports the outcome: 0 = same row already open (hit), 1 = no row open (empty), 2 = a different row open (conflict).
- R3: A request to an idle bank issues an activate of its row in the cycle after acceptance, once the other gaps allow it. The column command follows exactly T_RCD cycles after the activate.
- R4: Under open-page policy a hit issues only its column command, in the cycle after acceptance unless a gap holds it back, and the row stays open.
- R5: A conflict issues a precharge in the cycle after acceptance. The activate of the new row follows at the later of T_RP cycles after the precharge and T_RC cycles after the previous activate, and then the column command.
- R6: Under close-page policy (`policy_close` = 1) a precharge is issued in the cycle right after each column command. The next request is then reported as an empty-bank miss.
- R7: Two activates are never closer than T_RC cycles. When T_RC is the binding gap, the activate issues exactly T_RC cycles after the previous one.
- R8: A read column command is never closer than T_WTR cycles after a write column command. When T_WTR is the binding gap, it issues exactly T_WTR cycles after the write.
- R9: `req_ready` is 0 from the cycle after acceptance until the sequence for that request has ended. While it is 0, `req_valid` is ignored: it yields no `acc_valid` pulse and has no effect on the commands.
- R10: Command encoding on `cmd_op`: 0 = activate, 1 = read, 2 = write, 3 = precharge, valid when `cmd_valid` is 1. An activate carries the request row on `cmd_row`, and a read or write carries the request column on `cmd_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_close | input | 1 | 1 = close-page policy, 0 = open-page policy; static |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| cmd_valid | output | 1 | A bank command is issued this cycle |
| cmd_op | output | 2 | Command code (see R10) |
| cmd_row | output | ROW_W | Row carried with the command |
| cmd_col | output | COL_W | Column carried with the command |
| acc_valid | output | 1 | Outcome report for the last accepted request |
| acc_kind | output | 2 | Outcome: hit, empty or conflict (see R2) |

## Verification
A wrong open-row record shows up on the very next request. The outcome code is wrong in the cycle after acceptance, and the command run that follows has an extra or missing precharge or activate. A gap counter that is loaded wrong, or decrements wrong, moves a later command by one or more cycles. It is therefore caught by comparing command cycle numbers against the gap arithmetic of R3, R5, R7 and R8. A sequencer that drops back to idle too early shows as `req_ready` returning before the closing precharge, or as a stray outcome pulse during a busy sequence.

// File: rtl/bankctl_pkg.sv
// Package: shared command codes, outcome codes and sequencer states for the
// bank row-buffer sequencer. Assumes a single bank per sequencer instance.
package bankctl_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } bank_cmd_e;

    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_EMPTY    = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_ACT   = 3'd2,
        ST_COL   = 3'd3,
        ST_CLOSE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/bankctl_gap_timer.sv
// Module: minimum-spacing down-counter. A start pulse in cycle c makes
// `clear` low until cycle c+GAP, when it rises again. Assumes start
// is only pulsed by the command it follows; a restart reloads the count.
module bankctl_gap_timer #(
    parameter int unsigned GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic clear
);

    localparam int unsigned LOAD = (GAP > 0) ? GAP - 1 : 0;
    localparam int unsigned CW   = $clog2(LOAD + 2);

    logic [CW-1:0] cnt_q;

    // Load the gap on start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(LOAD);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The guarded command may issue once the count has drained.
    always_comb clear = (cnt_q == '0);

endmodule

// File: rtl/bankctl_row_track.sv
// Module: open-row tracker. Remembers whether a row sits in the row buffer
// and which row it is, and classifies a looked-up row as hit, empty or
// conflict. Assumes activate and precharge never coincide.
module bankctl_row_track
    import bankctl_pkg::*;
#(
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic [ROW_W-1:0] set_row,
    input  logic             close,
    input  logic [ROW_W-1:0] lookup_row,
    output acc_kind_e        lookup_kind
);

    logic             open_q;
    logic [ROW_W-1:0] row_q;

    // Record the activated row; precharge empties the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_set) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end else if (close) begin
            open_q <= 1'b0;
        end
    end

    // Classify the incoming row against the buffer contents.
    always_comb begin
        if (!open_q)                  lookup_kind = ACC_EMPTY;
        else if (row_q == lookup_row) lookup_kind = ACC_HIT;
        else                          lookup_kind = ACC_CONFLICT;
    end

    // R5: an activate is only legal on a precharged bank.
    p_act_on_closed_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        open_set |-> !open_q);

    // R6: a precharge is only issued while a row is open.
    p_pre_on_open_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        close |-> open_q);

endmodule

// File: rtl/bankctl_top.sv
// Module: bank row-buffer sequencer. Accepts one request at a time, works out
// hit/empty/conflict against the open row, and issues the command run that
// request needs under the selected row policy, each command held back by its
// gap timer. Assumes policy_close only changes while req_ready is high.
module bankctl_top
    import bankctl_pkg::*;
#(
    parameter int unsigned ROW_W = 12,
    parameter int unsigned COL_W = 8,
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_RC  = 10,
    parameter int unsigned T_WTR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             policy_close,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             cmd_valid,
    output logic [1:0]       cmd_op,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             acc_valid,
    output logic [1:0]       acc_kind
);

    localparam int unsigned AGE_MAX = (T_RC > T_RCD) ? T_RC : T_RCD;
    localparam int unsigned AGE_CAP = (AGE_MAX > T_WTR) ? AGE_MAX : T_WTR;
    localparam int unsigned AGE_W   = $clog2(AGE_CAP + 1);

    seq_state_e       state_q, state_d;
    logic             write_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             acc_valid_q;
    acc_kind_e        acc_kind_q;
    acc_kind_e        lookup_kind;

    logic rcd_clear, rp_clear, rc_clear, wtr_clear;
    logic act_go, col_go, pre_go, accept;

    // Handshake: a request is taken only from the idle state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_valid && req_ready;
    end

    // Command issue conditions, each gated by the gaps that guard it.
    always_comb begin
        act_go = (state_q == ST_ACT) && rp_clear && rc_clear;
        col_go = (state_q == ST_COL) && rcd_clear && (write_q || wtr_clear);
        pre_go = (state_q == ST_PRE) || (state_q == ST_CLOSE);
    end

    // Command port: one command per cycle, fields from the latched request.
    always_comb begin
        cmd_valid = act_go || col_go || pre_go;
        cmd_row   = row_q;
        cmd_col   = col_q;
        if (act_go)      cmd_op = CMD_ACT;
        else if (col_go) cmd_op = write_q ? CMD_WR : CMD_RD;
        else             cmd_op = CMD_PRE;
    end

    // Sequencer next state: pick the entry point from the row outcome.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (lookup_kind)
                        ACC_HIT:   state_d = ST_COL;
                        ACC_EMPTY: state_d = ST_ACT;
                        default:   state_d = ST_PRE;
                    endcase
                end
            end
            ST_PRE:   state_d = ST_ACT;
            ST_ACT:   if (act_go) state_d = ST_COL;
            ST_COL:   if (col_go) state_d = policy_close ? ST_CLOSE : ST_IDLE;
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            write_q <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                write_q <= req_write;
                row_q   <= req_row;
                col_q   <= req_col;
            end
        end
    end

    // Outcome report, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid_q <= 1'b0;
            acc_kind_q  <= ACC_HIT;
        end else begin
            acc_valid_q <= accept;
            if (accept) acc_kind_q <= lookup_kind;
        end
    end

    always_comb begin
        acc_valid = acc_valid_q;
        acc_kind  = acc_kind_q;
    end

    bankctl_row_track #(.ROW_W(ROW_W)) u_row_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_set    (act_go),
        .set_row     (row_q),
        .close       (pre_go),
        .lookup_row  (req_row),
        .lookup_kind (lookup_kind)
    );

    bankctl_gap_timer #(.GAP(T_RCD)) u_rcd_timer (
        .clk(clk), .rst_n(rst_n), .start(act_go), .clear(rcd_clear));

    bankctl_gap_timer #(.GAP(T_RP)) u_rp_timer (
        .clk(clk), .rst_n(rst_n), .start(pre_go), .clear(rp_clear));

    bankctl_gap_timer #(.GAP(T_RC)) u_rc_timer (
        .clk(clk), .rst_n(rst_n), .start(act_go), .clear(rc_clear));

    bankctl_gap_timer #(.GAP(T_WTR)) u_wtr_timer (
        .clk(clk), .rst_n(rst_n), .start(col_go && write_q), .clear(wtr_clear));

    // Checker ages: cycles since the last activate and since the last write.
    logic [AGE_W-1:0] act_age_q, wr_age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_age_q <= AGE_W'(AGE_CAP);
            wr_age_q  <= AGE_W'(AGE_CAP);
        end else begin
            if (cmd_valid && cmd_op == CMD_ACT)   act_age_q <= AGE_W'(1);
            else if (act_age_q < AGE_W'(AGE_CAP)) act_age_q <= act_age_q + 1'b1;
            if (cmd_valid && cmd_op == CMD_WR)    wr_age_q  <= AGE_W'(1);
            else if (wr_age_q < AGE_W'(AGE_CAP))  wr_age_q  <= wr_age_q + 1'b1;
        end
    end

    // R7: activate-to-activate spacing.
    p_act_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_ACT) |-> act_age_q >= AGE_W'(T_RC));

    // R8: write-to-read spacing.
    p_wr_rd_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_RD) |-> wr_age_q >= AGE_W'(T_WTR));

    // R3: a column command never precedes the activate-to-column gap.
    p_col_after_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == CMD_RD || cmd_op == CMD_WR)) |-> act_age_q >= AGE_W'(T_RCD));

    // R9: commands only while the request port is closed.
    p_busy_when_issuing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    // R2: an outcome report always follows an acceptance.
    p_report_follows_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(req_valid && req_ready));

    // R6: under close-page policy a column command is followed by a precharge.
    p_close_after_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == CMD_RD || cmd_op == CMD_WR) && policy_close)
        |=> (cmd_valid && cmd_op == CMD_PRE));

endmodule

// File: tb/test_bankctl_top.sv
module test_bankctl_top;
    import bankctl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 12;
    localparam int COL_W = 8;
    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int T_RC  = 10;
    localparam int T_WTR = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             policy_close = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             acc_valid;
    logic [1:0]       acc_kind;

    bankctl_top #(
        .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
        .T_RC(T_RC), .T_WTR(T_WTR)
    ) i_bankctl_top (
        .clk(clk), .rst_n(rst_n), .policy_close(policy_close),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .acc_valid(acc_valid), .acc_kind(acc_kind)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Command log, sampled away from the active edge.
    int lg_cyc [512];
    int lg_op  [512];
    int lg_row [512];
    int lg_col [512];
    int n_log = 0;
    int acc_seen = 0;
    always @(negedge clk) begin
        if (rst_n && cmd_valid && n_log < 512) begin
            lg_cyc[n_log] = cyc;
            lg_op[n_log]  = int'(cmd_op);
            lg_row[n_log] = int'(cmd_row);
            lg_col[n_log] = int'(cmd_col);
            n_log = n_log + 1;
        end
        if (rst_n && acc_valid) acc_seen = acc_seen + 1;
    end

    int checks = 0;
    int fails  = 0;
    int last_act = -1000;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int find_op(input int base, input int op, input int nth);
        int seen = 0;
        for (int i = base; i < n_log; i++) begin
            if (lg_op[i] == op) begin
                if (seen == nth) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Present one request, wait for acceptance, check the outcome pulse.
    task automatic do_req(input bit w, input int row, input int col,
                          output int acc, output int kind, output int base);
        @(negedge clk);
        base      = n_log;
        req_valid = 1'b1;
        req_write = w;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R2", "acc_valid one cycle after accept", int'(acc_valid), 1);
        kind = int'(acc_kind);
    endtask

    task automatic wait_done();
        while (!req_ready) @(negedge clk);
    endtask

    // R1: reset state.
    task automatic t_reset();
        @(negedge clk);
        check_eq("R1", "req_ready after reset", int'(req_ready), 1);
        check_eq("R1", "cmd_valid after reset", int'(cmd_valid), 0);
        check_eq("R1", "acc_valid after reset", int'(acc_valid), 0);
    endtask

    // R1/R3/R10: first read to an idle bank.
    task automatic t_first_read();
        int acc, kind, base, ia, ic;
        do_req(1'b0, 5, 2, acc, kind, base);
        check_eq("R1", "first request outcome empty", kind, 1);
        wait_done();
        check_eq("R3", "command count", n_log - base, 2);
        ia = find_op(base, 0, 0);
        ic = find_op(base, 1, 0);
        check_eq("R3", "activate cycle", (ia >= 0) ? lg_cyc[ia] : -1, acc);
        check_eq("R10", "activate row", (ia >= 0) ? lg_row[ia] : -1, 5);
        check_eq("R3", "read cycle", (ic >= 0) ? lg_cyc[ic] : -1, acc + T_RCD);
        check_eq("R10", "read column", (ic >= 0) ? lg_col[ic] : -1, 2);
        if (ia >= 0) last_act = lg_cyc[ia];
    endtask

    // R4: open-page hit needs only a column command.
    task automatic t_hit();
        int acc, kind, base;
        do_req(1'b0, 5, 7, acc, kind, base);
        check_eq("R4", "hit outcome", kind, 0);
        wait_done();
        check_eq("R4", "hit command count", n_log - base, 1);
        check_eq("R4", "hit op is read", lg_op[base], 1);
        check_eq("R4", "hit read cycle", lg_cyc[base], acc);
        check_eq("R10", "hit read column", lg_col[base], 7);
    endtask

    // R8: read after write to the open row waits T_WTR.
    task automatic t_write_read();
        int acc, kind, base, wr_c;
        do_req(1'b1, 5, 1, acc, kind, base);
        check_eq("R4", "write hit outcome", kind, 0);
        wait_done();
        check_eq("R10", "write op", lg_op[base], 2);
        check_eq("R10", "write column", lg_col[base], 1);
        wr_c = lg_cyc[base];
        do_req(1'b0, 5, 3, acc, kind, base);
        check_eq("R4", "read hit outcome", kind, 0);
        wait_done();
        check_eq("R8", "read after write command count", n_log - base, 1);
        check_eq("R8", "read cycle after write", lg_cyc[base], max2(acc, wr_c + T_WTR));
    endtask

    // R5/R7: conflict sequence, then a conflict bound by the activate gap.
    task automatic t_conflict(input bit w, input int row, input int col, input string req);
        int acc, kind, base, ip, ia, ic, exp_act;
        do_req(w, row, col, acc, kind, base);
        check_eq("R5", "conflict outcome", kind, 2);
        wait_done();
        ip = find_op(base, 3, 0);
        ia = find_op(base, 0, 0);
        ic = find_op(base, w ? 2 : 1, 0);
        check_eq("R5", "conflict command count", n_log - base, 3);
        check_eq("R5", "precharge cycle", (ip >= 0) ? lg_cyc[ip] : -1, acc);
        exp_act = max2(acc + T_RP, last_act + T_RC);
        check_eq(req, "activate cycle", (ia >= 0) ? lg_cyc[ia] : -1, exp_act);
        check_eq("R10", "activate row", (ia >= 0) ? lg_row[ia] : -1, row);
        check_eq("R5", "column cycle", (ic >= 0) ? lg_cyc[ic] : -1, exp_act + T_RCD);
        if (ia >= 0) last_act = lg_cyc[ia];
    endtask

    // R6/R9: close-page with ignored requests during the busy sequence.
    task automatic t_close_page();
        int acc, kind, base, ia, ic, ip, seen0, exp_act;
        @(negedge clk);
        policy_close = 1'b1;
        seen0 = acc_seen;
        do_req(1'b0, 3, 5, acc, kind, base);
        check_eq("R5", "close-page conflict outcome", kind, 2);
        // Busy window: offer a different row, it must be ignored.
        req_valid = 1'b1; req_row = ROW_W'(7); req_col = COL_W'(9);
        check_eq("R9", "req_ready low while busy", int'(req_ready), 0);
        @(negedge clk);
        check_eq("R9", "req_ready still low", int'(req_ready), 0);
        req_valid = 1'b0;
        wait_done();
        check_eq("R9", "outcome pulses over busy window", acc_seen - seen0, 1);
        check_eq("R6", "close-page command count", n_log - base, 4);
        ia = find_op(base, 0, 0);
        ic = find_op(base, 1, 0);
        ip = find_op(base, 3, 1);
        check_eq("R9", "activate row ignores busy request", (ia >= 0) ? lg_row[ia] : -1, 3);
        check_eq("R6", "precharge after read",
                 (ip >= 0) ? lg_cyc[ip] : -1, (ic >= 0) ? lg_cyc[ic] + 1 : -2);
        if (ia >= 0) last_act = lg_cyc[ia];
        // Same row again: the bank is closed, so it must be an empty miss.
        do_req(1'b1, 3, 6, acc, kind, base);
        check_eq("R6", "outcome after auto close", kind, 1);
        wait_done();
        ia = find_op(base, 0, 0);
        ic = find_op(base, 2, 0);
        ip = find_op(base, 3, 0);
        exp_act = max2(acc, last_act + T_RC);
        check_eq("R7", "activate after close", (ia >= 0) ? lg_cyc[ia] : -1, exp_act);
        check_eq("R6", "precharge after write",
                 (ip >= 0) ? lg_cyc[ip] : -1, (ic >= 0) ? lg_cyc[ic] + 1 : -2);
        if (ia >= 0) last_act = lg_cyc[ia];
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_read();
        t_hit();
        t_write_read();
        t_conflict(1'b0, 9, 4, "R5");
        t_conflict(1'b1, 12, 0, "R7");
        t_close_page();
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule